// File: doc/BRIEF.md
# Adaptive Output Rerouting Unit

This unit sits between the routing decision and six inter-chip output links. The upstream stage presents one packet at a time, with a one-hot code that names the target link. If that link accepts the packet, the packet leaves in the same cycle and no stall is raised. If the link refuses, the unit stalls the upstream stage and keeps offering the packet. Once the refusals reach a programmable wait count, or at once if the link reports that it has failed, the unit moves the packet to the next link clockwise. A packet sent on that alternative link carries a set reroute flag, so the receiver knows to pass it on in the right direction.

Only one alternative is tried. If the alternative link is failed, or refuses for a second programmable wait count, the packet is dropped and a drop counter increments. For every packet, exactly one outcome pulse reports whether it was sent normally, rerouted or dropped. Upstream uses a stall handshake: a packet counts as taken in a cycle where valid is high and stall is low, and upstream holds the packet steady while stall is high.

Top module: `adaptive_reroute`

## Requirements
- R1: After reset no link valid and no outcome pulse is asserted, the stall output is low while no packet is offered, and the drop count reads 0.
- R2: A packet whose target link is ready and not failed appears on that link in the same cycle, with the reroute flag at 0, together with a sent pulse and a low stall.
- R3: While the target link refuses without failing, the packet stays offered on it, data unchanged, for up to max(primary wait, 1) consecutive cycles counting the first offer. If the link accepts within that window, the outcome is sent.
- R4: After max(primary wait, 1) refusals, the packet is offered on link (target index + 1) mod 6, so link 5 wraps to link 0. The reroute flag is 1, and acceptance there gives a rerouted pulse.
- R5: A failed link never sees valid asserted. A packet whose target has failed moves to the alternative link in the next cycle, whatever the primary wait.
- R6: If the alternative link has failed, or refuses for max(alternate wait, 1) cycles, the packet is dropped in the last of those cycles with a dropped pulse, and the drop count increases by one.
- R7: Stall is high in every cycle of a packet except its final cycle (sent, rerouted or dropped), where it is low. A packet taken on its first offer never raises stall.
- R8: A wait setting of 0 behaves exactly as a setting of 1.
- R9: At most one link valid and at most one outcome pulse are asserted in any cycle, and every packet ends with exactly one outcome pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wait_pri | input | WAIT_W | Refusal cycles allowed on the target link before rerouting |
| cfg_wait_alt | input | WAIT_W | Refusal cycles allowed on the alternative link before dropping |
| in_valid | input | 1 | Upstream packet present |
| in_target | input | N_LINKS | One-hot target link |
| in_data | input | DATA_W | Packet payload |
| in_stall | output | 1 | Upstream must hold the packet |
| link_ready | input | N_LINKS | Per-link ready |
| link_fail | input | N_LINKS | Per-link failed status |
| out_valid | output | N_LINKS | Per-link valid, at most one bit set |
| out_data | output | DATA_W | Payload offered to the links |
| out_rerouted | output | 1 | Reroute flag travelling with the packet |
| res_sent | output | 1 | Pulse: packet sent on its target |
| res_rerouted | output | 1 | Pulse: packet sent on the alternative |
| res_dropped | output | 1 | Pulse: packet dropped |
| drop_count | output | CNT_W | Saturating count of dropped packets |

## Verification
The hardest case to reach is the boundary where a link turns ready in exactly the last cycle of its wait window. One cycle later on the target link turns a plain send into a reroute, and one cycle later on the alternative link turns a reroute into a drop. The stimulus schedules, for each packet, the cycle at which the target link and the alternative link turn ready, along with random failure masks and wait settings from 0 to 5. Directed packets place the ready cycle exactly at the last cycle of each window and one cycle past it, including the wrap from link 5 to link 0.

// File: rtl/reroute_pkg.sv
// Package: shared types for the adaptive output rerouting unit.
// Assumes: nothing; holds only the controller state encoding.
package reroute_pkg;

    // Controller state: idle, waiting on the target link, waiting on the alternative.
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_PRIMARY   = 2'd1,
        ST_ALTERNATE = 2'd2
    } rr_state_t;

endpackage

// File: rtl/reroute_alt_sel.sv
// Module: reroute_alt_sel
// Rotates a one-hot link code by one place, so link i maps to link (i+1) mod N.
// Assumes: the input is one-hot or zero; the output is then the same.
module reroute_alt_sel #(
    parameter int N_LINKS = 6
) (
    input  logic [N_LINKS-1:0] tgt,
    output logic [N_LINKS-1:0] alt
);

    // One wire per link, wrapping the highest link back to link 0.
    for (genvar i = 0; i < N_LINKS; i++) begin : g_rot
        assign alt[(i + 1) % N_LINKS] = tgt[i];
    end

endmodule

// File: rtl/reroute_fsm.sv
// Module: reroute_fsm
// Tracks one packet through the target wait, the alternative wait and the final outcome.
// Assumes: upstream holds in_valid and the packet while the unit stalls, and the wait
// settings stay constant while a packet is in flight.
module reroute_fsm
    import reroute_pkg::*;
#(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              link_ok,
    input  logic              link_dead,
    input  logic [WAIT_W-1:0] cfg_wait_pri,
    input  logic [WAIT_W-1:0] cfg_wait_alt,
    output rr_state_t         state,
    output logic              ev_sent,
    output logic              ev_rerouted,
    output logic              ev_dropped
);

    logic [WAIT_W-1:0] cnt, cnt_nxt;
    logic [WAIT_W:0]   cnt_inc;
    rr_state_t         state_nxt;

    assign cnt_inc = {1'b0, cnt} + 1'b1;

    // Next-state and outcome decode for the current offer.
    always_comb begin
        state_nxt   = state;
        cnt_nxt     = cnt;
        ev_sent     = 1'b0;
        ev_rerouted = 1'b0;
        ev_dropped  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (in_valid) begin
                    if (link_ok) begin
                        ev_sent = 1'b1;
                    end else if (link_dead || ({1'b0, cfg_wait_pri} <= 1)) begin
                        state_nxt = ST_ALTERNATE;
                        cnt_nxt   = '0;
                    end else begin
                        state_nxt = ST_PRIMARY;
                        cnt_nxt   = WAIT_W'(1);
                    end
                end
            end
            ST_PRIMARY: begin
                if (!in_valid) begin
                    state_nxt = ST_IDLE;
                end else if (link_ok) begin
                    ev_sent   = 1'b1;
                    state_nxt = ST_IDLE;
                end else if (link_dead || (cnt_inc >= {1'b0, cfg_wait_pri})) begin
                    state_nxt = ST_ALTERNATE;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt_inc[WAIT_W-1:0];
                end
            end
            ST_ALTERNATE: begin
                if (!in_valid) begin
                    state_nxt = ST_IDLE;
                end else if (link_ok) begin
                    ev_rerouted = 1'b1;
                    state_nxt   = ST_IDLE;
                end else if (link_dead || (cnt_inc >= {1'b0, cfg_wait_alt})) begin
                    ev_dropped = 1'b1;
                    state_nxt  = ST_IDLE;
                end else begin
                    cnt_nxt = cnt_inc[WAIT_W-1:0];
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State and refusal counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // R9: never more than one outcome in a cycle.
    a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_sent, ev_rerouted, ev_dropped}));

    // R6: a dropped packet leaves the controller idle.
    a_r6_drop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ev_dropped |=> state == ST_IDLE);

    // R3: the target wait never runs past its window.
    a_r3_primary_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIMARY) |-> ({1'b0, cnt} < {1'b0, cfg_wait_pri}));

endmodule

// File: rtl/reroute_drop_ctr.sv
// Module: reroute_drop_ctr
// Counts dropped packets and holds at all ones instead of wrapping.
// Assumes: the drop pulse lasts one cycle per dropped packet.
module reroute_drop_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drop,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Saturating increment on each drop.
    always_ff @(posedge clk) begin
        if (!rst_n)                       count <= '0;
        else if (drop && count != CNT_MAX) count <= count + 1'b1;
    end

    // R6: each drop below saturation adds exactly one.
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && count != CNT_MAX) |=> count == $past(count) + 1'b1);

endmodule

// File: rtl/adaptive_reroute.sv
// Module: adaptive_reroute (top)
// Offers each upstream packet to its one-hot target link. When that link is congested
// or failed, it stalls upstream and moves the packet to the next link clockwise, setting a
// reroute flag. If that link is blocked too, it drops the packet and counts the drop.
// Assumes: upstream holds valid, target and data steady while in_stall is high, and the
// target code is one-hot.
module adaptive_reroute
    import reroute_pkg::*;
#(
    parameter int N_LINKS = 6,
    parameter int DATA_W  = 32,
    parameter int WAIT_W  = 8,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WAIT_W-1:0]  cfg_wait_pri,
    input  logic [WAIT_W-1:0]  cfg_wait_alt,
    input  logic               in_valid,
    input  logic [N_LINKS-1:0] in_target,
    input  logic [DATA_W-1:0]  in_data,
    output logic               in_stall,
    input  logic [N_LINKS-1:0] link_ready,
    input  logic [N_LINKS-1:0] link_fail,
    output logic [N_LINKS-1:0] out_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_rerouted,
    output logic               res_sent,
    output logic               res_rerouted,
    output logic               res_dropped,
    output logic [CNT_W-1:0]   drop_count
);

    rr_state_t          state;
    logic [N_LINKS-1:0] alt_tgt;
    logic [N_LINKS-1:0] cur_tgt;
    logic               link_ok;
    logic               link_dead;

    reroute_alt_sel #(.N_LINKS(N_LINKS)) u_alt (
        .tgt (in_target),
        .alt (alt_tgt)
    );

    // Select the link being offered and read its status.
    always_comb begin
        cur_tgt   = (state == ST_ALTERNATE) ? alt_tgt : in_target;
        link_ok   = |(cur_tgt & link_ready & ~link_fail);
        link_dead = |(cur_tgt & link_fail);
    end

    reroute_fsm #(.WAIT_W(WAIT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .link_ok      (link_ok),
        .link_dead    (link_dead),
        .cfg_wait_pri (cfg_wait_pri),
        .cfg_wait_alt (cfg_wait_alt),
        .state        (state),
        .ev_sent      (res_sent),
        .ev_rerouted  (res_rerouted),
        .ev_dropped   (res_dropped)
    );

    reroute_drop_ctr #(.CNT_W(CNT_W)) u_drop (
        .clk   (clk),
        .rst_n (rst_n),
        .drop  (res_dropped),
        .count (drop_count)
    );

    // Drive the link side and the upstream stall.
    always_comb begin
        out_valid    = in_valid ? (cur_tgt & ~link_fail) : '0;
        out_data     = in_data;
        out_rerouted = (state == ST_ALTERNATE);
        in_stall     = in_valid & ~(res_sent | res_rerouted | res_dropped);
    end

    // R9: at most one link sees valid.
    a_r9_single_link: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    // R4: a rerouted outcome goes out flagged on a live link.
    a_r4_flag_on_reroute: assert property (@(posedge clk) disable iff (!rst_n)
        res_rerouted |-> (out_rerouted && (out_valid != '0)));

    // R7: a stalled packet is still offered, unchanged, in the next cycle.
    a_r7_held_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        in_stall |=> (in_valid && $stable(in_data) && $stable(in_target)));

endmodule

// File: tb/adaptive_reroute_test.sv
module adaptive_reroute_test;

    localparam int NL = 6;
    localparam int DW = 32;
    localparam int WW = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [WW-1:0] cfg_wait_pri = '0, cfg_wait_alt = '0;
    logic          in_valid = 1'b0;
    logic [NL-1:0] in_target = '0;
    logic [DW-1:0] in_data = '0;
    logic          in_stall;
    logic [NL-1:0] link_ready = '0, link_fail = '0;
    logic [NL-1:0] out_valid;
    logic [DW-1:0] out_data;
    logic          out_rerouted, res_sent, res_rerouted, res_dropped;
    logic [CW-1:0] drop_count;

    int checks = 0;
    int fails = 0;
    int exp_drops = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    adaptive_reroute #(.N_LINKS(NL), .DATA_W(DW), .WAIT_W(WW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wait_pri(cfg_wait_pri), .cfg_wait_alt(cfg_wait_alt),
        .in_valid(in_valid), .in_target(in_target), .in_data(in_data), .in_stall(in_stall),
        .link_ready(link_ready), .link_fail(link_fail), .out_valid(out_valid),
        .out_data(out_data), .out_rerouted(out_rerouted), .res_sent(res_sent),
        .res_rerouted(res_rerouted), .res_dropped(res_dropped), .drop_count(drop_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Outcome codes: 0 sent, 1 rerouted, 2 dropped.
    task automatic run_packet(input string lbl, input int t, input logic [NL-1:0] fm,
                              input int dp, input int da, input int wp, input int wa,
                              input logic [DW-1:0] d);
        int w, a, s, e, outc, alt;
        logic [NL-1:0] expv;
        w = max2(wp, 1);
        a = max2(wa, 1);
        alt = (t + 1) % NL;
        s = fm[t] ? 1 : w;
        if (!fm[t] && dp < w) begin
            outc = 0; e = dp;
        end else if (fm[alt]) begin
            outc = 2; e = s;
        end else if (max2(s, da) - s < a) begin
            outc = 1; e = max2(s, da);
        end else begin
            outc = 2; e = s + a - 1;
        end
        @(negedge clk);
        cfg_wait_pri = WW'(wp);
        cfg_wait_alt = WW'(wa);
        for (int c = 0; c <= e; c++) begin
            if (c > 0) @(negedge clk);
            in_valid = 1'b1;
            in_target = NL'(1) << t;
            in_data = d;
            link_fail = fm;
            link_ready = NL'($urandom);
            link_ready[t] = (c >= dp);
            link_ready[alt] = (c >= da);
            #1;
            expv = '0;
            if (c < s) begin
                if (!fm[t]) expv[t] = 1'b1;
            end else begin
                if (!fm[alt]) expv[alt] = 1'b1;
            end
            chk(out_valid == expv, (c < s) ? (fm[t] ? "R5" : "R3") : (fm[alt] ? "R5" : "R4"),
                {lbl, " link valid"}, out_valid, expv);
            if (expv != '0) begin
                chk(out_data == d, "R3", {lbl, " data"}, out_data, d);
                chk(out_rerouted == (c >= s), (c >= s) ? "R4" : "R2",
                    {lbl, " reroute flag"}, out_rerouted, (c >= s));
            end
            if (c < e) begin
                chk(in_stall == 1'b1, "R7", {lbl, " stall while waiting"}, in_stall, 1);
                chk({res_sent, res_rerouted, res_dropped} == 3'b000, "R9",
                    {lbl, " early outcome"}, {res_sent, res_rerouted, res_dropped}, 0);
            end else begin
                chk(in_stall == 1'b0, "R7", {lbl, " stall at final cycle"}, in_stall, 0);
                chk({res_sent, res_rerouted, res_dropped} == (3'b100 >> outc),
                    (outc == 0) ? ((e == 0) ? "R2" : "R3") : ((outc == 1) ? "R4" : "R6"),
                    {lbl, " outcome"}, {res_sent, res_rerouted, res_dropped}, 3'b100 >> outc);
            end
        end
        if (outc == 2) exp_drops++;
        @(negedge clk);
        in_valid = 1'b0;
        link_ready = NL'($urandom);
        #1;
        chk(drop_count == CW'(exp_drops), "R6", {lbl, " drop count"}, drop_count, exp_drops);
        chk(out_valid == '0 && !in_stall, "R7", {lbl, " idle after packet"},
            {in_stall, out_valid}, 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == '0, "R1", "reset link valid", out_valid, 0);
        chk(!in_stall, "R1", "reset stall", in_stall, 0);
        chk(drop_count == '0, "R1", "reset drop count", drop_count, 0);
        chk({res_sent, res_rerouted, res_dropped} == 3'b000, "R1", "reset outcome",
            {res_sent, res_rerouted, res_dropped}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corner cases.
        run_packet("R2 direct",          2, 6'b000000, 0, 0, 3, 3, 32'hA5A5_0001);
        run_packet("R3 last primary",    1, 6'b000000, 2, 0, 3, 3, 32'hA5A5_0002);
        run_packet("R4 one past primary", 1, 6'b000000, 3, 3, 3, 3, 32'hA5A5_0003);
        run_packet("R4 wrap 5 to 0",     5, 6'b000000, 9, 4, 2, 3, 32'hA5A5_0004);
        run_packet("R6 alt last cycle",  3, 6'b000000, 9, 5, 3, 3, 32'hA5A5_0005);
        run_packet("R6 alt one late",    3, 6'b000000, 9, 6, 3, 3, 32'hA5A5_0006);
        run_packet("R5 failed target",   0, 6'b000001, 0, 0, 5, 2, 32'hA5A5_0007);
        run_packet("R5 failed alt",      4, 6'b100000, 9, 0, 2, 4, 32'hA5A5_0008);
        run_packet("R5 both failed",     5, 6'b100001, 0, 0, 4, 4, 32'hA5A5_0009);
        run_packet("R8 zero waits",      2, 6'b000000, 9, 9, 0, 0, 32'hA5A5_000A);
        run_packet("R8 zero waits alt",  2, 6'b000000, 9, 1, 0, 0, 32'hA5A5_000B);

        // Random packets over targets, failures, ready timing and wait settings.
        for (int i = 0; i < 400; i++) begin
            logic [NL-1:0] fm;
            fm = '0;
            for (int k = 0; k < NL; k++) fm[k] = ($urandom % 5) == 0;
            run_packet("R9 random", int'($urandom % NL), fm, int'($urandom % 11),
                       int'($urandom % 11), int'($urandom % 6), int'($urandom % 6),
                       $urandom);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule